// File: doc/BRIEF.md
# Packed-24 Pixel Group Aligner

This block sits on a pixel bus that carries 24-bit true-color pixels packed densely into bus words, so that one pixel group of N pixels occupies M = 3 consecutive words. A line-active strobe marks the horizontal active region. The first load on which the strobe is seen high fixes the start of the line. The word that becomes word 0 of the first group is either that load itself or the load two loads later, as a delay setting chooses. From then on a word-phase counter runs modulo 3, and each completed group is unpacked into its N separate pixels.

The block works in a single clock domain. A load-enable strobe marks each bus-word load edge, and a dot-enable strobe stands in for the dot clock. Only one of the three word phases in a group is treated as lined up with the dot sequence, and a two-bit edge-select input picks which one. A completed group is handed to the unpacker on the first later load whose phase equals that selection. Pixels then leave one per dot strobe with a valid flag. Two packings are supported: four pixels in three 32-bit words (narrow) and eight pixels in three 64-bit words (wide). Configuration inputs are static while the line strobe is high.

Top module: `p24_group_aligner`

## Requirements
- R1: While reset is held and after it is released with no line active, `pix_vld` is 0 and `pix_out` is 0.
- R2: With `start_dly` = 0, the first load (`ld_en` = 1) on which `line_act` is sampled high captures word 0 of the first group.
- R3: With `start_dly` = 1, the words of the first two loads that see `line_act` high are discarded, and the third such load captures word 0.
- R4: After word 0, every further load advances the word phase 0, 1, 2, 0, ... and each third word completes a group, so consecutive groups follow with no gap or overlap.
- R5: With `wide_mode` = 0, a group is three 32-bit words taken from `bus_word[31:0]` (bits 63:32 ignored). Pixel i (i = 0..3) is bits [24i+23:24i] of the 96-bit value {w2, w1, w0}, where w0 is word 0.
- R6: With `wide_mode` = 1, a group is three 64-bit words. Pixel i (i = 0..7) is bits [24i+23:24i] of the 192-bit value {w2, w1, w0}.
- R7: A completed group is handed to the unpacker on the first later load whose word phase equals `edge_sel`. With a dot strobe every cycle, the first pixel of a line is valid in the cycle after load number 2*`start_dly` + 3 + `edge_sel`, where the first load that sees `line_act` high is load number 0.
- R8: An `edge_sel` value of 3, which lies beyond the last phase, acts as phase 2.
- R9: Pixels leave in order 0..N-1 of each group, one per cycle with `dot_en` = 1 on the preceding clock edge; `pix_vld` is never 1 without that.
- R10: When `line_act` is low on a clock edge, the word phase, the partially filled group, a completed group still waiting and the pixels not yet sent are discarded, and none of them is ever output. The next load that sees `line_act` high starts alignment again.
- R11: When `edge_sel` selects phase 2, the handover of group k and the completion of group k+1 fall on the same load, and both groups are output intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wide_mode | input | 1 | 0: 4 pixels in three 32-bit words; 1: 8 pixels in three 64-bit words |
| start_dly | input | 1 | 0: first sampled load is word 0; 1: word 0 is two loads later |
| edge_sel | input | 2 | Word phase aligned with the dot sequence (3 acts as 2) |
| line_act | input | 1 | Line-active strobe; low means blanking |
| ld_en | input | 1 | Marks a bus-word load edge |
| bus_word | input | BUS_W | Packed pixel bus word |
| dot_en | input | 1 | Dot strobe; one pixel may leave per strobe |
| pix_out | output | PIX_W | Unpacked 24-bit pixel |
| pix_vld | output | 1 | pix_out holds a new pixel |

## Verification
Two functions can meet on one load: the capture of the third word that completes group k+1, and the handover of the waiting group k to the unpacker. This happens whenever the edge select points at phase 2, or at 3, which acts as 2. The bench provokes it by streaming several back-to-back groups of random pixels at each edge-select value in both packings. The scoreboard then requires every pixel of every group in exact order, which it can only get if the waiting group is read before it is overwritten and the new group stays pending. First-pixel timing is measured against the load count set by the delay and edge-select settings.

// File: rtl/p24_pkg.sv
package p24_pkg;

    // Line alignment state: blanking, counting skipped loads, capturing
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } start_st_e;

endpackage

// File: rtl/p24_start_ctl.sv
module p24_start_ctl
    import p24_pkg::*;
#(
    parameter int DLY_LOADS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_act,
    input  logic ld_en,
    input  logic dly_en,
    output logic cap_en
);

    localparam int CNT_W = (DLY_LOADS > 1) ? $clog2(DLY_LOADS) : 1;

    typedef struct packed {
        start_st_e        st;
        logic [CNT_W-1:0] cnt;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        cap_en = 1'b0;
        if (!line_act) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
        end else if (ld_en) begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (dly_en) begin
                        ctl_d.st  = ST_WAIT;
                        ctl_d.cnt = CNT_W'(DLY_LOADS - 1);
                    end else begin
                        cap_en   = 1'b1;
                        ctl_d.st = ST_RUN;
                    end
                end
                ST_WAIT: begin
                    if (ctl_q.cnt == '0) begin
                        cap_en   = 1'b1;
                        ctl_d.st = ST_RUN;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
                default: cap_en = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_DIRECT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && line_act && ld_en && !dly_en) |=> (ctl_q.st == ST_RUN)); // R2

    AST_DELAY_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && line_act && ld_en && dly_en) |-> !cap_en); // R3

    AST_LOW_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_act |-> !cap_en); // R10

endmodule

// File: rtl/p24_word_cap.sv
module p24_word_cap #(
    parameter int WORDS = 3,
    parameter int BUS_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cap_en,
    input  logic                   wide,
    input  logic [1:0]             edge_sel,
    input  logic [BUS_W-1:0]       word_in,
    output logic                   xfer,
    output logic [WORDS*BUS_W-1:0] grp_out
);

    localparam int PH_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int HALF_W = BUS_W / 2;
    localparam int FLAT_W = WORDS * BUS_W;

    typedef struct packed {
        logic [PH_W-1:0]             ph;
        logic [WORDS-1:0][BUS_W-1:0] words;
        logic [FLAT_W-1:0]           hold;
        logic                        pend;
    } cap_s;

    cap_s cap_d, cap_q;

    logic [PH_W-1:0]             sel_ph;
    logic [WORDS-1:0][BUS_W-1:0] cur_w;
    logic [FLAT_W-1:0]           packed_flat;
    logic                        aligned;

    always_comb begin
        // Phase selections past the last word fold onto the last word
        if (32'(edge_sel) >= WORDS) begin
            sel_ph = PH_W'(WORDS - 1);
        end else begin
            sel_ph = PH_W'(edge_sel);
        end
        aligned = cap_en && (cap_q.ph == sel_ph);
        xfer    = aligned && cap_q.pend;

        for (int j = 0; j < WORDS; j++) begin
            cur_w[j] = (cap_en && (PH_W'(j) == cap_q.ph)) ? word_in : cap_q.words[j];
        end

        packed_flat = '0;
        for (int j = 0; j < WORDS; j++) begin
            if (wide) begin
                packed_flat[j*BUS_W +: BUS_W] = cur_w[j];
            end else begin
                packed_flat[j*HALF_W +: HALF_W] = cur_w[j][HALF_W-1:0];
            end
        end

        cap_d = cap_q;
        if (clr) begin
            cap_d = '0;
        end else begin
            if (xfer) begin
                cap_d.pend = 1'b0;
            end
            if (cap_en) begin
                cap_d.words = cur_w;
                if (cap_q.ph == PH_W'(WORDS - 1)) begin
                    cap_d.ph   = '0;
                    cap_d.hold = packed_flat;
                    cap_d.pend = 1'b1;
                end else begin
                    cap_d.ph = cap_q.ph + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign grp_out = cap_q.hold;

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !clr && cap_q.ph == PH_W'(WORDS - 1)) |=> (cap_q.ph == '0 && cap_q.pend)); // R4

    AST_COINCIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !clr && cap_q.ph == PH_W'(WORDS - 1)) |=> cap_q.pend); // R11

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!cap_q.pend && cap_q.ph == '0)); // R10

endmodule

// File: rtl/p24_unpack.sv
module p24_unpack #(
    parameter int PIX_W    = 24,
    parameter int FLAT_W   = 192,
    parameter int N_WIDE   = 8,
    parameter int N_NARROW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              wide,
    input  logic [FLAT_W-1:0] grp_in,
    input  logic              dot_en,
    output logic [PIX_W-1:0]  pix,
    output logic              pix_vld
);

    localparam int CNT_W = $clog2(N_WIDE + 1);

    typedef struct packed {
        logic [FLAT_W-1:0] sh;
        logic [CNT_W-1:0]  rem;
        logic [PIX_W-1:0]  pix;
        logic              vld;
    } unp_s;

    unp_s unp_d, unp_q;

    always_comb begin
        unp_d     = unp_q;
        unp_d.vld = 1'b0;
        if (clr) begin
            unp_d = '0;
        end else if (load) begin
            unp_d.sh  = grp_in;
            unp_d.rem = wide ? CNT_W'(N_WIDE) : CNT_W'(N_NARROW);
        end else if (dot_en && unp_q.rem != '0) begin
            unp_d.pix = unp_q.sh[PIX_W-1:0];
            unp_d.vld = 1'b1;
            unp_d.sh  = unp_q.sh >> PIX_W;
            unp_d.rem = unp_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unp_q <= '0;
        end else begin
            unp_q <= unp_d;
        end
    end

    assign pix     = unp_q.pix;
    assign pix_vld = unp_q.vld;

    AST_VLD_NEEDS_DOT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(dot_en)); // R9

endmodule

// File: rtl/p24_group_aligner.sv
module p24_group_aligner #(
    parameter int PIX_W     = 24,
    parameter int BUS_W     = 64,
    parameter int WORDS     = 3,
    parameter int DLY_LOADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             start_dly,
    input  logic [1:0]       edge_sel,
    input  logic             line_act,
    input  logic             ld_en,
    input  logic [BUS_W-1:0] bus_word,
    input  logic             dot_en,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld
);

    localparam int HALF_W   = BUS_W / 2;
    localparam int FLAT_W   = WORDS * BUS_W;
    localparam int N_WIDE   = FLAT_W / PIX_W;
    localparam int N_NARROW = (WORDS * HALF_W) / PIX_W;

    logic              cap_en;
    logic              xfer;
    logic              blank;
    logic [FLAT_W-1:0] grp;

    assign blank = !line_act;

    p24_start_ctl #(
        .DLY_LOADS (DLY_LOADS)
    ) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_act (line_act),
        .ld_en    (ld_en),
        .dly_en   (start_dly),
        .cap_en   (cap_en)
    );

    p24_word_cap #(
        .WORDS (WORDS),
        .BUS_W (BUS_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (blank),
        .cap_en   (cap_en),
        .wide     (wide_mode),
        .edge_sel (edge_sel),
        .word_in  (bus_word),
        .xfer     (xfer),
        .grp_out  (grp)
    );

    p24_unpack #(
        .PIX_W    (PIX_W),
        .FLAT_W   (FLAT_W),
        .N_WIDE   (N_WIDE),
        .N_NARROW (N_NARROW)
    ) u_unpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blank),
        .load    (xfer),
        .wide    (wide_mode),
        .grp_in  (grp),
        .dot_en  (dot_en),
        .pix     (pix_out),
        .pix_vld (pix_vld)
    );

    AST_BLANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !line_act |=> !pix_vld); // R10

endmodule

// File: tb/p24_group_aligner_tb.sv
`timescale 1ns/1ps
module p24_group_aligner_tb;

    localparam int PIX_W = 24;
    localparam int BUS_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wide_mode = 1'b0;
    logic             start_dly = 1'b0;
    logic [1:0]       edge_sel = 2'd0;
    logic             line_act = 1'b0;
    logic             ld_en = 1'b0;
    logic [BUS_W-1:0] bus_word = '0;
    logic             dot_en = 1'b1;
    logic [PIX_W-1:0] pix_out;
    logic             pix_vld;

    always #2 clk = ~clk;

    p24_group_aligner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .start_dly (start_dly),
        .edge_sel  (edge_sel),
        .line_act  (line_act),
        .ld_en     (ld_en),
        .bus_word  (bus_word),
        .dot_en    (dot_en),
        .pix_out   (pix_out),
        .pix_vld   (pix_vld)
    );

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 0;
    bit          dot_gap = 0;
    logic        dot_last = 1'b0;
    logic [23:0] exp_q[$];
    string       tag = "R5";
    bit          first_seen = 0;
    int          first_cyc = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        dot_last <= dot_en;
    end

    always @(posedge clk) begin
        #1;
        dot_en = dot_gap ? ~dot_en : 1'b1;
    end

    // Monitor: pops expected pixels and compares
    always @(negedge clk) begin
        if (rst_n && pix_vld) begin
            if (!first_seen) begin
                first_seen = 1;
                first_cyc  = cyc;
            end
            chk(dot_last == 1'b1, "R9", "pixel without dot strobe", dot_last, 1);
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected pixel", pix_out, 0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk(pix_out === e, tag, "pixel order/value", pix_out, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_word(logic [63:0] w, int per);
        ld_en    = 1'b1;
        bus_word = w;
        tick();
        ld_en    = 1'b0;
        bus_word = {$urandom, $urandom};
        repeat (per - 1) tick();
    endtask

    // Driver: packs random pixels, pushes them to the scoreboard, drives loads
    task automatic run(bit wide, bit dly, logic [1:0] es, int per, int groups, bit tail, bit gap);
        int          n;
        int          ee;
        int          t0;
        int          exp_lat;
        logic [191:0] flat;
        logic [63:0]  w;
        n  = wide ? 8 : 4;
        ee = (es > 2) ? 2 : int'(es);
        wide_mode  = wide;
        start_dly  = dly;
        edge_sel   = es;
        dot_gap    = gap;
        tag        = wide ? "R6" : "R5";
        first_seen = 0;
        tick();
        t0       = cyc + 1;
        line_act = 1'b1;
        if (dly) begin
            load_word({$urandom, $urandom}, per);
            load_word({$urandom, $urandom}, per);
        end
        for (int g = 0; g < groups; g++) begin
            flat = '0;
            for (int i = 0; i < n; i++) begin
                logic [23:0] p;
                p = 24'($urandom);
                flat[i*24 +: 24] = p;
                if (tail || g < groups - 1) exp_q.push_back(p);
            end
            for (int j = 0; j < 3; j++) begin
                if (wide) w = flat[j*64 +: 64];
                else      w = {$urandom, flat[j*32 +: 32]};
                load_word(w, per);
            end
        end
        if (tail) begin
            for (int j = 0; j < 3; j++) load_word({$urandom, $urandom}, per);
        end
        repeat (30) tick();
        line_act = 1'b0;
        repeat (3) tick();
        chk(exp_q.size() == 0, (ee == 2) ? "R11" : "R4", "pixels left undelivered", exp_q.size(), 0);
        exp_q.delete();
        if (tail && !gap) begin
            exp_lat = t0 + (2 * int'(dly) + 3 + ee) * per + 1;
            chk(first_seen && first_cyc == exp_lat,
                $sformatf("%s/%s", dly ? "R3" : "R2", (es == 3) ? "R8" : "R7"),
                "first pixel cycle", first_cyc, exp_lat);
        end
        if (!tail) begin
            chk(!first_seen, "R10", "pending group emitted after blanking", first_seen, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs quiet even with activity on the inputs
        line_act = 1'b1;
        repeat (3) begin
            ld_en    = 1'b1;
            bus_word = {$urandom, $urandom};
            tick();
        end
        ld_en    = 1'b0;
        line_act = 1'b0;
        chk(pix_vld == 1'b0, "R1", "pix_vld during reset", pix_vld, 0);
        rst_n = 1'b1;
        repeat (4) tick();
        chk(pix_vld == 1'b0, "R1", "pix_vld after reset", pix_vld, 0);
        chk(pix_out == '0, "R1", "pix_out after reset", pix_out, 0);

        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int e = 0; e < 4; e++) begin
                    run(m[0], d[0], e[1:0], (m == 1) ? 3 : 2, 3, 1'b1, 1'b0);
                end
            end
        end

        // R9: dot strobe only every other cycle
        run(1'b0, 1'b0, 2'd1, 3, 4, 1'b1, 1'b1);

        // R10: completed group still waiting when blanking starts
        run(1'b0, 1'b0, 2'd2, 2, 1, 1'b0, 1'b0);
        run(1'b1, 1'b1, 2'd2, 3, 1, 1'b0, 1'b0);

        // R10: partial group dropped, then alignment restarts
        tick();
        line_act = 1'b1;
        load_word({$urandom, $urandom}, 2);
        load_word({$urandom, $urandom}, 2);
        line_act = 1'b0;
        repeat (4) tick();
        run(1'b0, 1'b1, 2'd0, 2, 2, 1'b1, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule